// File: doc/BRIEF.md
# I2C Master Clock Pacer with Bus Synchronization

This block produces the clock timing for the controller side of an I2C link. The bus clock is open-drain, so its level is the AND of every device on the wire. The pacer pulls the line low for a programmed number of cycles and then lets go. It times the high phase only from the moment it actually sees the line high. Its counters follow the real bus level rather than a free-running divider. Because of that, a target device can stretch any low phase, or hold the clock low after a byte, and the pacer simply waits.

Each finished high phase gives a one-cycle bit pulse, and every ninth pulse also gives a byte-done pulse (eight data bits plus acknowledge). A small event unit collects three events into sticky status bits and one pending flag: byte done, address match and arbitration lost. The pending flag is write-one-to-clear and is gated onto a single interrupt line. The data shifter, START/STOP logic and register access sit outside the block.

Top module: `scl_pacer`

## Requirements
- R1: While enable_i is low (including from reset) scl_pull_o, bit_strobe_o, byte_done_o, pending_o and irq_o stay low. Dropping enable_i releases scl_pull_o by the next cycle and resets the bit count.
- R2: scl_i passes through a two-flop synchronizer. The low-phase count restarts at the synchronized falling edge, and with no other device holding the clock the bus stays low for L+2 cycles, where L is the effective low count.
- R3: When another device holds the clock low longer, the bus low time equals that device's hold. The pacer has released its own pull and waits without driving new edges.
- R4: The high-phase count starts only when the synchronized bus is high. The bus high time is always H+3 cycles, where H is the effective high count, however long the wait before it was.
- R5: A programmed low or high count of 0 behaves as 1.
- R6: bit_strobe_o is a one-cycle pulse at the end of every high phase. A high phase cut short by the bus going low also ends with a pulse and restarts the low count.
- R7: byte_done_o pulses together with every ninth bit_strobe_o since the block was enabled.
- R8: run_i is sampled at the end of each high phase. If it is low, the pacer finishes that bit, issues no further strobe and leaves scl_pull_o low.
- R9: Three events each set their own status bit and the pending flag on the next cycle: byte done (stat_byte_o), addr_match_i (stat_addr_o) and arb_lost_i (stat_arb_o).
- R10: A clr_i pulse clears pending_o and all status bits. An event in the same cycle wins, so pending_o and that event's status bit stay set.
- R11: irq_o is high exactly when pending_o and irq_en_i are both high.
- R12: Events arriving while enable_i is low set neither the status bits nor pending_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Block enable |
| run_i | input | 1 | Keep generating clock bits |
| low_cnt_i | input | 8 | Low-phase length in cycles (0 = 1) |
| high_cnt_i | input | 8 | High-phase length in cycles (0 = 1) |
| scl_i | input | 1 | Sampled bus clock level |
| irq_en_i | input | 1 | Interrupt enable |
| addr_match_i | input | 1 | Address-match event pulse |
| arb_lost_i | input | 1 | Arbitration-lost event pulse |
| clr_i | input | 1 | Write-one-to-clear strobe for pending and status |
| scl_pull_o | output | 1 | Open-drain pull-down enable for the bus clock |
| bit_strobe_o | output | 1 | One-cycle pulse per finished clock bit |
| byte_done_o | output | 1 | One-cycle pulse on every ninth bit |
| stat_byte_o | output | 1 | Sticky byte-done status |
| stat_addr_o | output | 1 | Sticky address-match status |
| stat_arb_o | output | 1 | Sticky arbitration-lost status |
| pending_o | output | 1 | Pending interrupt flag |
| irq_o | output | 1 | Gated interrupt line |

## Verification
The clear strobe and a new event can land in the same cycle. The bench provokes this by pulsing clr_i together with arb_lost_i while the address-match status is set. The case passes if pending_o stays high, stat_arb_o is set and stat_addr_o is cleared. The timing side uses a modelled target that stretches every low phase by a random amount. Each bus low run is compared with the longer of the stretch and L+2, and each bus high run with H+3.

// File: rtl/scl_pacer_pkg.sv
`timescale 1ns/1ps
package scl_pacer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_REL  = 2'd2,
    ST_HIGH = 2'd3
  } pace_state_e;

  localparam int unsigned N_EVT = 3;

  typedef struct packed {
    logic byte_done;
    logic addr_match;
    logic arb_lost;
  } evt_t;
endpackage

// File: rtl/scl_pacer_sync.sv
`timescale 1ns/1ps
module scl_pacer_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b1;   // idle bus is high
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/scl_pacer_timer.sv
`timescale 1ns/1ps
module scl_pacer_timer
  import scl_pacer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic             scl_s_i,
  output logic             pull_o,
  output logic             strobe_o
);
  localparam int unsigned CW = CNT_W + 1;

  pace_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_low_nxt;
  logic [CW-1:0] low_eff, high_eff;
  logic          scl_prev_q, fall;
  logic          strobe_q, strobe_d;

  assign low_eff  = (low_cnt_i  == '0) ? CW'(1) : {1'b0, low_cnt_i};
  assign high_eff = (high_cnt_i == '0) ? CW'(1) : {1'b0, high_cnt_i};
  assign fall     = scl_prev_q & ~scl_s_i;
  // count restarts from the synchronized falling edge
  assign cnt_low_nxt = fall ? CW'(1) : cnt_q + 1'b1;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    strobe_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (run_i) begin
          state_d = ST_LOW;
          cnt_d   = '0;
        end
      end
      ST_LOW: begin
        if (!scl_s_i) begin
          cnt_d = cnt_low_nxt;
          if (cnt_low_nxt >= low_eff) state_d = ST_REL;
        end
      end
      ST_REL: begin
        // wait time for stretching devices is not part of the high count
        if (scl_s_i) begin
          state_d = ST_HIGH;
          cnt_d   = CW'(1);
        end
      end
      ST_HIGH: begin
        if (!scl_s_i) begin
          strobe_d = 1'b1;
          state_d  = run_i ? ST_LOW : ST_IDLE;
          cnt_d    = CW'(1);
        end else if (cnt_q >= high_eff) begin
          strobe_d = 1'b1;
          state_d  = run_i ? ST_LOW : ST_IDLE;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (!enable_i) begin
      state_d  = ST_IDLE;
      cnt_d    = '0;
      strobe_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      scl_prev_q <= 1'b1;
      strobe_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      scl_prev_q <= scl_s_i;
      strobe_q   <= strobe_d;
    end
  end

  assign pull_o   = (state_q == ST_LOW);
  assign strobe_o = strobe_q;
endmodule

// File: rtl/scl_pacer_bitcnt.sv
`timescale 1ns/1ps
module scl_pacer_bitcnt #(
  parameter int unsigned BITS = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic strobe_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(BITS);

  logic [W-1:0] cnt_q;
  logic         last;

  assign last = (cnt_q == W'(BITS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!enable_i) cnt_q <= '0;
    else if (strobe_i)  cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  assign done_o = strobe_i & last;
endmodule

// File: rtl/scl_pacer_irq.sv
`timescale 1ns/1ps
module scl_pacer_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enable_i,
  input  logic         irq_en_i,
  input  logic [N-1:0] ev_i,
  input  logic         clr_i,
  output logic [N-1:0] stat_o,
  output logic         pending_o,
  output logic         irq_o
);
  logic [N-1:0] ev_g, stat_q;
  logic         pend_q;

  assign ev_g = ev_i & {N{enable_i}};

  generate
    for (genvar i = 0; i < N; i++) begin : g_stat
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q[i] <= 1'b0;
        else         stat_q[i] <= ev_g[i] | (stat_q[i] & ~clr_i);
      end
    end
  endgenerate

  // new event beats a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (|ev_g) | (pend_q & ~clr_i);
  end

  assign stat_o    = stat_q;
  assign pending_o = pend_q;
  assign irq_o     = pend_q & irq_en_i;
endmodule

// File: rtl/scl_pacer.sv
`timescale 1ns/1ps
module scl_pacer
  import scl_pacer_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned BITS        = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic             scl_i,
  input  logic             irq_en_i,
  input  logic             addr_match_i,
  input  logic             arb_lost_i,
  input  logic             clr_i,
  output logic             scl_pull_o,
  output logic             bit_strobe_o,
  output logic             byte_done_o,
  output logic             stat_byte_o,
  output logic             stat_addr_o,
  output logic             stat_arb_o,
  output logic             pending_o,
  output logic             irq_o
);
  logic scl_s, strobe, done;
  evt_t ev, stat;

  scl_pacer_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (scl_i),
    .q_o   (scl_s)
  );

  scl_pacer_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .run_i     (run_i),
    .low_cnt_i (low_cnt_i),
    .high_cnt_i(high_cnt_i),
    .scl_s_i   (scl_s),
    .pull_o    (scl_pull_o),
    .strobe_o  (strobe)
  );

  scl_pacer_bitcnt #(.BITS(BITS)) u_bitcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .strobe_i(strobe),
    .done_o  (done)
  );

  assign ev.byte_done  = done;
  assign ev.addr_match = addr_match_i;
  assign ev.arb_lost   = arb_lost_i;

  scl_pacer_irq #(.N(N_EVT)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .irq_en_i (irq_en_i),
    .ev_i     (ev),
    .clr_i    (clr_i),
    .stat_o   (stat),
    .pending_o(pending_o),
    .irq_o    (irq_o)
  );

  assign bit_strobe_o = strobe;
  assign byte_done_o  = done;
  assign stat_byte_o  = stat.byte_done;
  assign stat_addr_o  = stat.addr_match;
  assign stat_arb_o   = stat.arb_lost;
endmodule

// File: rtl/scl_pacer_chk.sv
`timescale 1ns/1ps
module scl_pacer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic addr_match_i,
  input logic arb_lost_i,
  input logic clr_i,
  input logic scl_pull_o,
  input logic bit_strobe_o,
  input logic byte_done_o,
  input logic stat_arb_o,
  input logic pending_o
);
  assert_release_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !scl_pull_o);

  assert_strobe_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_strobe_o |=> !bit_strobe_o);

  assert_byte_on_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> bit_strobe_o);

  assert_arb_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && arb_lost_i) |=> (pending_o && stat_arb_o));

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(enable_i && (addr_match_i || arb_lost_i || byte_done_o))) |=> !pending_o);

  assert_ignore_off_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !pending_o) |=> !pending_o);
endmodule

bind scl_pacer scl_pacer_chk u_chk (.*);

// File: tb/scl_pacer_test.sv
`timescale 1ns/1ps
module scl_pacer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, run = 1'b0, irq_en = 1'b0;
  logic addr = 1'b0, arb = 1'b0, clr = 1'b0;
  logic [7:0] lo = 8'd4, hi = 8'd4;
  logic pull, strobe, bdone, s_byte, s_addr, s_arb, pending, irq;
  logic hold = 1'b0;
  wire  scl_bus = ~(pull | hold);

  int checks = 0, fails = 0;
  int strobe_cnt = 0, run_len = 0, exp_low = 0, rem = 0;
  logic measure = 1'b0, seen_low = 1'b0, stretch_en = 1'b0;
  logic bus_neg = 1'b1, bus_pos_prev = 1'b1;
  int unused_seed;

  always #2.5 clk = ~clk;

  scl_pacer uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .run_i(run),
    .low_cnt_i(lo), .high_cnt_i(hi), .scl_i(scl_bus), .irq_en_i(irq_en),
    .addr_match_i(addr), .arb_lost_i(arb), .clr_i(clr),
    .scl_pull_o(pull), .bit_strobe_o(strobe), .byte_done_o(bdone),
    .stat_byte_o(s_byte), .stat_addr_o(s_addr), .stat_arb_o(s_arb),
    .pending_o(pending), .irq_o(irq)
  );

  function automatic int eff(input logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus run-length measurement and strobe bookkeeping, sampled mid-cycle
  always @(negedge clk) begin
    if (!measure) seen_low = 1'b0;
    if (scl_bus == bus_neg) run_len++;
    else begin
      if (measure) begin
        if (bus_neg && seen_low)
          chk(run_len == eff(hi) + 3, "R4 R5 high time", run_len, eff(hi) + 3);
        else if (!bus_neg) begin
          chk(run_len == exp_low, "R2 R3 R5 low time", run_len, exp_low);
          seen_low = 1'b1;
        end
      end
      run_len = 1;
      bus_neg = scl_bus;
    end
    if (!enable) strobe_cnt = 0;
    else if (strobe) begin
      chk(bdone == ((strobe_cnt % 9) == 8), "R7 byte done", int'(bdone), int'((strobe_cnt % 9) == 8));
      strobe_cnt++;
    end else if (bdone) chk(1'b0, "R7 byte done without strobe", 1, 0);
  end

  // target model: stretches each low phase by a random amount
  always @(posedge clk) begin
    if (!bus_neg && bus_pos_prev) begin
      if (stretch_en) begin
        int s;
        s = $urandom_range(1, 60);
        hold    <= 1'b1;
        rem     <= s;
        exp_low <= max2(s + 1, eff(lo) + 2);
      end else exp_low <= eff(lo) + 2;
    end else if (rem > 1) rem <= rem - 1;
    else if (rem == 1) begin
      rem  <= 0;
      hold <= 1'b0;
    end
    bus_pos_prev <= bus_neg;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic burst(input logic [7:0] l, input logic [7:0] h, input bit st, input int nb);
    int start;
    step();
    lo = l; hi = h; stretch_en = st; measure = 1'b1;
    start = strobe_cnt;
    run = 1'b1;
    while (strobe_cnt < start + nb) step();
    run = 1'b0;
    repeat (700) step();
    measure = 1'b0;
    chk(strobe_cnt == start + nb + 1, "R6 R8 strobes after stop", strobe_cnt, start + nb + 1);
    chk(pull == 1'b0, "R8 released after stop", int'(pull), 0);
  endtask

  task automatic ev(input bit c, input bit a, input bit r);
    step();
    clr = c; addr = a; arb = r;
    step();
    clr = 1'b0; addr = 1'b0; arb = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    unused_seed = $urandom(32'd20240);
    repeat (5) step();
    rst_n = 1'b1;
    irq_en = 1'b1;
    run = 1'b1;
    repeat (30) step();
    chk(pull == 1'b0, "R1 no pull while disabled", int'(pull), 0);
    chk(strobe_cnt == 0, "R1 no strobe while disabled", strobe_cnt, 0);
    chk(pending == 1'b0, "R1 pending after reset", int'(pending), 0);
    chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
    run = 1'b0;
    enable = 1'b1;
    irq_en = 1'b0;
    repeat (5) step();

    burst(8'd5, 8'd7, 1'b0, 18);
    burst(8'd12, 8'd4, 1'b1, 27);
    burst(8'd0, 8'd0, 1'b1, 9);
    burst(8'd200, 8'd30, 1'b1, 9);
    for (int i = 0; i < 5; i++)
      burst(8'($urandom_range(0, 40)), 8'($urandom_range(0, 40)),
            1'($urandom_range(0, 1)), $urandom_range(5, 20));

    chk(pending == 1'b1, "R9 byte event pending", int'(pending), 1);
    chk(s_byte == 1'b1, "R9 byte status", int'(s_byte), 1);
    chk(irq == 1'b0, "R11 irq masked", int'(irq), 0);
    irq_en = 1'b1; #1;
    chk(irq == 1'b1, "R11 irq enabled", int'(irq), 1);

    ev(1'b1, 1'b0, 1'b0);
    chk(pending == 1'b0, "R10 clear pending", int'(pending), 0);
    chk(s_byte == 1'b0, "R10 clear byte status", int'(s_byte), 0);
    chk(irq == 1'b0, "R11 irq after clear", int'(irq), 0);

    ev(1'b0, 1'b1, 1'b0);
    chk(pending == 1'b1, "R9 addr pending", int'(pending), 1);
    chk(s_addr == 1'b1, "R9 addr status", int'(s_addr), 1);
    chk(s_arb == 1'b0, "R9 arb status idle", int'(s_arb), 0);

    ev(1'b1, 1'b0, 1'b1);
    chk(pending == 1'b1, "R10 event wins over clear", int'(pending), 1);
    chk(s_arb == 1'b1, "R10 arb status kept", int'(s_arb), 1);
    chk(s_addr == 1'b0, "R10 addr status cleared", int'(s_addr), 0);
    ev(1'b1, 1'b0, 1'b0);
    chk(pending == 1'b0, "R10 second clear", int'(pending), 0);

    // disable mid-transfer
    step();
    lo = 8'd10; hi = 8'd10; stretch_en = 1'b0; run = 1'b1;
    repeat (40) step();
    while (pull == 1'b0) step();
    enable = 1'b0;
    step();
    chk(pull == 1'b0, "R1 release on disable", int'(pull), 0);
    repeat (30) step();
    chk(strobe_cnt == 0, "R1 no strobe after disable", strobe_cnt, 0);
    chk(pull == 1'b0, "R1 stays released", int'(pull), 0);

    ev(1'b0, 1'b1, 1'b1);
    chk(pending == 1'b0, "R12 events ignored pending", int'(pending), 0);
    chk(s_addr == 1'b0, "R12 events ignored addr", int'(s_addr), 0);
    chk(s_arb == 1'b0, "R12 events ignored arb", int'(s_arb), 0);
    chk(irq == 1'b0, "R12 R11 no irq", int'(irq), 0);
    run = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule